// File: doc/BRIEF.md
# SPI Register Access Port

This block is an SPI mode-0 slave that turns serial command words into byte reads and writes on a simple internal bus. That bus carries an address, write data, a write strobe, a read strobe and returned read data. It serves a register file and a packet buffer. The buffer holds a transmit area that starts at address 0x000 and a receive area that starts at address 0x300.

A transaction starts with one command byte or two. The most significant bit of the first byte picks the format:

- A short command is one byte and reaches a 6-bit address space.
- A long command is two bytes and reaches a 10-bit address space.

Data bytes follow the command for as long as chip select stays low. The address advances by one after each byte, so a whole received frame can be read in a single burst. A received frame is laid out as a length byte, then the frame bytes, then a link-quality byte and a signal-strength byte. A frame can also be written into the transmit area in one burst.

SCK, chip select and MOSI are brought into the system clock domain by two-flop synchronizers. The system clock must run at least eight times faster than SCK, so 80 MHz or more for a 10 MHz SCK. MOSI is sampled on the rising edge of SCK and MISO changes on the falling edge. Both are sent MSB first.

Top module: `spi_regport`

## Requirements
- R1: A first byte with bit 7 = 0 is a short command: bits 6:1 are the address and bit 0 = 1 means write. For a write, the next byte is written to that address with one write strobe.
- R2: For a short command with bit 0 = 0, the byte stored at the address is shifted out on MISO, MSB first, during the byte that follows the command.
- R3: A first byte with bit 7 = 1 starts a long command. The two bytes form a 16-bit word in which bits 14:5 are the address and bit 4 = 1 means write. Bits 3:0 are ignored. The third byte is the data, and a read returns it on MISO during that byte.
- R4: After a long write command, every further data byte taken while chip select is low goes to the next consecutive address.
- R5: A long read continues for any number of bytes and returns consecutive locations. A full receive-area frame at 0x300 comes back in order: length, frame bytes, link quality, signal strength.
- R6: In a short burst the address increments within the 6-bit space, so address 0x3F is followed by 0x00.
- R7: In a long burst the address increments within the 10-bit space, so address 0x3FF is followed by 0x000.
- R8: Raising chip select at any point ends the transaction. A partly received data byte is never written, and the next transaction is decoded from a fresh command.
- R9: Every write strobe and every read strobe lasts exactly one system clock. The two strobes are never high together, and the address is held in the cycle after a write strobe.
- R10: MISO is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock, idles low |
| csn | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| bus_addr | output | 10 | Internal bus address |
| bus_wdata | output | 8 | Internal bus write data |
| bus_we | output | 1 | Write strobe, one cycle |
| bus_re | output | 1 | Read strobe, one cycle |
| bus_rdata | input | 8 | Read data, valid the cycle after bus_re |

## Verification
A rising SCK edge reaches the decoder about three system clocks after it occurs. A strobe therefore comes out about three cycles after the last rising edge of a byte. The bench's bus model stores written data on the following clock, so the bench checks memory contents only after chip select has risen, at least eight cycles later.

Read data comes back the cycle after the read strobe and is captured one cycle after that. It is loaded onto MISO at the falling edge that ends the command byte. The bench samples MISO half an SCK period later, on the clock just before it raises SCK. Strobe width and strobe overlap are checked on every falling clock edge, away from the edges at which the design updates.

// File: rtl/spi_regport.sv
module spi_regport (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       csn,
  input  logic       mosi,
  output logic       miso,
  output logic [9:0] bus_addr,
  output logic [7:0] bus_wdata,
  output logic       bus_we,
  output logic       bus_re,
  input  logic [7:0] bus_rdata
);

  typedef enum logic [1:0] {ST_CMD, ST_LADR, ST_DATA} st_t;

  logic [2:0] sck_q;
  logic [1:0] mosi_q, csn_q;
  logic [6:0] sh, hi;
  logic [2:0] bcnt;
  st_t        st;
  logic       is_wr, is_long, re_d;
  logic [9:0] ptr;
  logic [7:0] pre, tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      csn_q  <= 2'b11;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
      csn_q  <= {csn_q[0], csn};
    end
  end

  wire       active  = ~csn_q[1];
  wire       rise    = sck_q[1] & ~sck_q[2];
  wire       fall    = ~sck_q[1] & sck_q[2];
  wire [7:0] byte_in = {sh, mosi_q[1]};
  wire       done    = active & rise & (bcnt == 3'd7);
  wire [9:0] ptr_nx  = is_long ? ptr + 10'd1 : {4'd0, ptr[5:0] + 6'd1};
  wire [9:0] ladr    = {hi, byte_in[7:5]};

  assign miso = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      hi        <= '0;
      bcnt      <= '0;
      st        <= ST_CMD;
      is_wr     <= 1'b0;
      is_long   <= 1'b0;
      re_d      <= 1'b0;
      ptr       <= '0;
      pre       <= '0;
      tx        <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
    end else begin
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      re_d   <= bus_re;
      if (re_d) pre <= bus_rdata;
      if (!active) begin
        bcnt <= '0;
        st   <= ST_CMD;
        tx   <= '0;
      end else begin
        if (rise) begin
          sh   <= byte_in[6:0];
          bcnt <= bcnt + 3'd1;
        end
        if (fall)
          tx <= (bcnt == 3'd0 && st == ST_DATA && !is_wr) ? pre : {tx[6:0], 1'b0};
        if (done) begin
          case (st)
            ST_CMD: begin
              if (byte_in[7]) begin
                hi      <= byte_in[6:0];
                is_long <= 1'b1;
                st      <= ST_LADR;
              end else begin
                is_long <= 1'b0;
                is_wr   <= byte_in[0];
                st      <= ST_DATA;
                if (byte_in[0]) begin
                  ptr <= {4'd0, byte_in[6:1]};
                end else begin
                  bus_addr <= {4'd0, byte_in[6:1]};
                  bus_re   <= 1'b1;
                  ptr      <= {4'd0, byte_in[6:1] + 6'd1};
                end
              end
            end
            ST_LADR: begin
              is_wr <= byte_in[4];
              st    <= ST_DATA;
              if (byte_in[4]) begin
                ptr <= ladr;
              end else begin
                bus_addr <= ladr;
                bus_re   <= 1'b1;
                ptr      <= ladr + 10'd1;
              end
            end
            default: begin
              bus_addr <= ptr;
              ptr      <= ptr_nx;
              if (is_wr) begin
                bus_wdata <= byte_in;
                bus_we    <= 1'b1;
              end else begin
                bus_re <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n,
  input logic       we,
  input logic       re,
  input logic [9:0] addr,
  input logic       miso
);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(we && re));

  // R9
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) we |=> !we);

  // R9
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) re |=> !re);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) we |=> $stable(addr));

  // R8
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) sel_n |=> !we);

  // R10
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) sel_n |=> !miso);

endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .sel_n(csn_q[1]),
  .we   (bus_we),
  .re   (bus_re),
  .addr (bus_addr),
  .miso (miso)
);

// File: tb/spi_regport_tb.sv
module spi_regport_tb;

  localparam int CLK_NS = 10;
  localparam int HALF   = 4;

  // {long, addr[9:0], data[7:0]}
  localparam logic [18:0] VEC [0:5] = '{
    {1'b0, 10'h001, 8'hA5},
    {1'b0, 10'h03E, 8'h5A},
    {1'b1, 10'h123, 8'hC3},
    {1'b1, 10'h2FF, 8'h81},
    {1'b0, 10'h020, 8'h00},
    {1'b1, 10'h07F, 8'hFF}
  };

  logic       clk = 1'b0, rst_n = 1'b0, sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso, bus_we, bus_re;
  logic [9:0] bus_addr;
  logic [7:0] bus_wdata, rdata_q;

  spi_regport u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi), .miso(miso),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(rdata_q)
  );

  always #(CLK_NS/2) clk = ~clk;

  logic [7:0] mem [0:1023];
  always @(posedge clk) begin
    if (bus_we) mem[bus_addr] <= bus_wdata;
    if (bus_re) rdata_q <= mem[bus_addr];
  end

  int   checks = 0, fails = 0, wr_cnt = 0, ovl = 0, wide = 0;
  logic we_prev = 1'b0, re_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_we && bus_re) ovl++;
      if ((bus_we && we_prev) || (bus_re && re_prev)) wide++;
      if (bus_we) wr_cnt++;
    end
    we_prev <= bus_we;
    re_prev <= bus_re;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] tb_tx [0:15];
  logic [7:0] tb_rx [0:15];

  function automatic int put_cmd(input bit lg, input logic [9:0] a, input bit w);
    if (lg) begin
      tb_tx[0] = {1'b1, a[9:3]};
      tb_tx[1] = {a[2:0], w, 4'b0000};
      return 2;
    end
    tb_tx[0] = {1'b0, a[5:0], w};
    return 1;
  endfunction

  task automatic xfer(input int nbytes, input int stop_bit);
    int nb;
    nb = 0;
    @(negedge clk);
    csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbytes; i++) begin
      for (int b = 7; b >= 0; b--) begin
        if (stop_bit == 0 || nb < stop_bit) begin
          mosi = tb_tx[i][b];
          repeat (HALF) @(negedge clk);
          tb_rx[i][b] = miso;
          sck = 1'b1;
          repeat (HALF) @(negedge clk);
          sck = 1'b0;
          nb++;
        end
      end
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, w0;
    for (int i = 0; i < 1024; i++) mem[i] = i[7:0] ^ 8'h5C;
    mem[10'h300] = 8'd5;
    for (int i = 0; i < 5; i++) mem[10'h301 + i] = 8'h10 + i[7:0];
    mem[10'h306] = 8'hEE;
    mem[10'h307] = 8'h44;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 R9: reset state
    chk(miso == 1'b0, "R10 reset miso", miso, 0);
    chk(!bus_we && !bus_re, "R9 reset strobes", {bus_we, bus_re}, 0);

    // R1 R2 R3: vector table, write then read back
    for (int i = 0; i < 6; i++) begin
      logic       lg;
      logic [9:0] a;
      logic [7:0] d;
      {lg, a, d} = VEC[i];
      n = put_cmd(lg, a, 1'b1);
      tb_tx[n] = d;
      xfer(n + 1, 0);
      chk(mem[a] == d, lg ? "R3 write" : "R1 write", mem[a], d);
      n = put_cmd(lg, a, 1'b0);
      tb_tx[n] = 8'h00;
      xfer(n + 1, 0);
      chk(tb_rx[n] == d, lg ? "R3 read" : "R2 read", tb_rx[n], d);
    end

    // R3: low nibble of long command ignored
    tb_tx[0] = {1'b1, 7'h2A};
    tb_tx[1] = {3'b101, 1'b1, 4'hF};
    tb_tx[2] = 8'h3C;
    xfer(3, 0);
    chk(mem[10'h155] == 8'h3C, "R3 nibble", mem[10'h155], 8'h3C);

    // R4: long write burst
    n = put_cmd(1'b1, 10'h010, 1'b1);
    for (int k = 0; k < 4; k++) tb_tx[n + k] = 8'hB0 + k[7:0];
    xfer(n + 4, 0);
    for (int k = 0; k < 4; k++)
      chk(mem[10'h010 + k] == 8'hB0 + k[7:0], "R4 burst", mem[10'h010 + k], 8'hB0 + k);

    // R5: receive frame read in one burst
    n = put_cmd(1'b1, 10'h300, 1'b0);
    for (int k = 0; k < 8; k++) tb_tx[n + k] = 8'h00;
    xfer(n + 8, 0);
    chk(tb_rx[n] == 8'd5, "R5 length", tb_rx[n], 5);
    for (int k = 0; k < 5; k++)
      chk(tb_rx[n + 1 + k] == 8'h10 + k[7:0], "R5 frame", tb_rx[n + 1 + k], 8'h10 + k);
    chk(tb_rx[n + 6] == 8'hEE, "R5 lqi", tb_rx[n + 6], 8'hEE);
    chk(tb_rx[n + 7] == 8'h44, "R5 rssi", tb_rx[n + 7], 8'h44);

    // R6: short burst wraps 0x3F -> 0x00
    n = put_cmd(1'b0, 10'h03F, 1'b1);
    tb_tx[n] = 8'h61;
    tb_tx[n + 1] = 8'h62;
    xfer(n + 2, 0);
    chk(mem[10'h03F] == 8'h61, "R6 last", mem[10'h03F], 8'h61);
    chk(mem[10'h000] == 8'h62, "R6 wrap", mem[10'h000], 8'h62);
    chk(mem[10'h040] == (8'h40 ^ 8'h5C), "R6 no spill", mem[10'h040], 8'h40 ^ 8'h5C);

    // R7: long burst wraps 0x3FF -> 0x000
    n = put_cmd(1'b1, 10'h3FF, 1'b1);
    tb_tx[n] = 8'h71;
    tb_tx[n + 1] = 8'h72;
    xfer(n + 2, 0);
    chk(mem[10'h3FF] == 8'h71, "R7 last", mem[10'h3FF], 8'h71);
    chk(mem[10'h000] == 8'h72, "R7 wrap", mem[10'h000], 8'h72);

    // R8: abort after 5 data bits
    w0 = wr_cnt;
    n = put_cmd(1'b0, 10'h005, 1'b1);
    tb_tx[n] = 8'h77;
    xfer(n + 1, 13);
    chk(mem[10'h005] == (8'h05 ^ 8'h5C), "R8 partial", mem[10'h005], 8'h05 ^ 8'h5C);
    chk(wr_cnt == w0, "R8 no strobe", wr_cnt, w0);
    n = put_cmd(1'b0, 10'h005, 1'b0);
    tb_tx[n] = 8'h00;
    xfer(n + 1, 0);
    chk(tb_rx[n] == (8'h05 ^ 8'h5C), "R8 fresh cmd", tb_rx[n], 8'h05 ^ 8'h5C);

    // R9 R10: strobe shape and idle MISO
    chk(ovl == 0, "R9 overlap", ovl, 0);
    chk(wide == 0, "R9 width", wide, 0);
    chk(miso == 1'b0, "R10 idle miso", miso, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule